// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block is an on-chip logic-analyzer core. While it is armed it takes a snapshot of a bus of probed internal signals on every rising clock edge and stores it in a circular sample memory. A trigger is built from one or more stages. Each stage compares the probe bus against a value under a mask, and the stages have to be met one after another. After the final stage is met, capture goes on for a programmed number of further samples and then freezes. The memory then holds a window of `DEPTH` samples with the trigger event placed early in it, in the middle, or late.

Capture runs as four states. In `S_IDLE` nothing is written. In `S_ARMED` every sample is written and the block hunts for the trigger sequence. In `S_POST` the trigger has been seen and the block keeps writing until the post-trigger quota is used up. In `S_DONE` the memory is frozen and can be read. The transitions are named as follows. Arm leads from any state to `S_ARMED`. Stop leads from any state to `S_IDLE`. Trigger-hit leads from `S_ARMED` to `S_POST`, or straight to `S_DONE` when the quota is one sample. Quota-filled leads from `S_POST` to `S_DONE`. After capture the host pulses `rd_en` once per sample, and the samples come back oldest first, together with the position of the trigger sample inside that sequence.

Top module: `trig_capture`

## Requirements
- R1: After reset `armed`, `triggered`, `done` and `rd_valid` are all 0.
- R2: An `arm` pulse, unless `stop` is high, gives `armed`=1, `triggered`=0 and `done`=0 on the next cycle. From whatever state it is taken, it clears the stage counter and the sample count, and it latches `pos_sel`.
- R3: In `S_ARMED` and `S_POST` the probe value present at each rising edge is written to the next memory slot, with no gaps.
- R4: Stage i uses `trig_val[i*PROBE_W +: PROBE_W]` and `trig_mask[i*PROBE_W +: PROBE_W]`. The stage matches when every probe bit equals its value bit in the same sample, except that a mask bit of 1 makes that bit a don't-care.
- R5: Stages are met in order, from 0 to `used_stages`-1, at most one per sample. A match of a later stage before the earlier stages have been met has no effect. A `used_stages` of 0 acts as 1, and values above `STAGES` are clipped.
- R6: The `pos_sel` latched at arm sets the pre-trigger quota PRE: 0 gives 1 sample, 1 gives `DEPTH`/2, 2 gives `DEPTH`-1, and 3 acts as 1. The trigger sample and the samples after it fill the remaining `DEPTH`-PRE slots.
- R7: A final-stage match is ignored until at least PRE samples have been written since arm.
- R8: On the trigger, `triggered` rises on the next cycle. `done` rises once the post quota is written, and at that point `armed` falls.
- R9: In `S_DONE` each `rd_en` cycle returns one sample with `rd_valid` on the following cycle. The first sample is the oldest, and successive reads step forward and wrap after `DEPTH` samples.
- R10: In `S_DONE`, `trig_pos` equals the index of the trigger sample within the readout sequence, which is PRE.
- R11: `stop` returns the block to `S_IDLE` on the next cycle from any state, without setting `done`, and it wins over `arm`.
- R12: `rd_en` outside `S_DONE` produces no `rd_valid`.
- R13: `done` stays high until `arm` or `stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe | input | PROBE_W | Probed signal bus |
| trig_val | input | STAGES*PROBE_W | Compare value for each stage |
| trig_mask | input | STAGES*PROBE_W | Don't-care mask for each stage (1 = ignore bit) |
| used_stages | input | $clog2(STAGES+1) | Number of stages in the sequence |
| pos_sel | input | 2 | Trigger position: 0 early, 1 center, 2 late |
| arm | input | 1 | Start capture |
| stop | input | 1 | Abort, back to idle |
| rd_en | input | 1 | Read next stored sample |
| armed | output | 1 | Capture running |
| triggered | output | 1 | Trigger seen |
| done | output | 1 | Window frozen, readable |
| trig_pos | output | $clog2(DEPTH) | Readout index of the trigger sample |
| rd_data | output | PROBE_W | Read sample |
| rd_valid | output | 1 | rd_data valid |

## Verification
A wrong stage counter or sample count does not show up at once. It shows up hundreds of cycles later: the trigger fires early or late, and the readout window then moves as a whole, so every sample read back is off by the same amount. Driving the probe with a free-running count makes each stored sample name the cycle it came from. Any error in the pointers or the quotas therefore appears as a wrong value in the first word read back, one cycle after the first `rd_en`. Errors in the state register show up on the status flags one cycle after the `arm` or `stop` that exposes them.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {S_IDLE, S_ARMED, S_POST, S_DONE} cap_state_e;

    localparam logic [1:0] POS_PRE    = 2'd0;
    localparam logic [1:0] POS_CENTER = 2'd1;
    localparam logic [1:0] POS_POST   = 2'd2;
endpackage

// File: rtl/cap_match.sv
module cap_match #(
    parameter int PROBE_W = 8,
    parameter int STAGES  = 2
) (
    input  logic [PROBE_W-1:0]        probe,
    input  logic [STAGES*PROBE_W-1:0] trig_val,
    input  logic [STAGES*PROBE_W-1:0] trig_mask,
    output logic [STAGES-1:0]         hit
);
    // one comparator per stage: all unmasked bits must agree
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign hit[i] = ((probe ^ trig_val[i*PROBE_W +: PROBE_W])
                         & ~trig_mask[i*PROBE_W +: PROBE_W]) == '0;
    end
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [PROBE_W-1:0] wdata,
    input  logic               re,
    input  logic [AW-1:0]      raddr,
    output logic [PROBE_W-1:0] rdata
);
    logic [PROBE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
    import cap_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(STAGES + 1),
    localparam int GW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] hit,
    input  logic [SW-1:0]     used_stages,
    input  logic [1:0]        pos_sel,
    input  logic              arm,
    input  logic              stop,
    input  logic              rd_en,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic              re,
    output logic [AW-1:0]     raddr,
    output logic              armed,
    output logic              triggered,
    output logic              done,
    output logic [AW-1:0]     trig_pos,
    output logic              rd_valid
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    cap_state_e  state, state_nx;
    logic [AW-1:0] wp, wp_inc, trig_ptr, rp;
    logic [AW:0]   cnt, rem, pre_need, post_quota;
    logic [GW-1:0] stage, last_stage;
    logic [1:0]    pos_q;
    logic          final_hit, rd_go, arm_go;

    assign arm_go = arm && !stop;
    assign wp_inc = wp + AW'(1);

    always_comb begin
        if (used_stages == '0)             last_stage = '0;
        else if (used_stages > SW'(STAGES)) last_stage = GW'(STAGES - 1);
        else                                last_stage = GW'(used_stages - SW'(1));
    end

    always_comb begin
        case (pos_q)
            POS_CENTER: pre_need = (AW+1)'(DEPTH / 2);
            POS_POST:   pre_need = (AW+1)'(DEPTH - 1);
            default:    pre_need = (AW+1)'(1);
        endcase
    end

    assign post_quota = FULL - pre_need;
    assign final_hit  = (stage == last_stage) && hit[stage] && (cnt >= pre_need);
    assign rd_go      = (state == S_DONE) && rd_en && !stop && !arm;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop)        state_nx = S_IDLE;
        else if (arm)    state_nx = S_ARMED;
        else begin
            unique case (state)
                S_IDLE:  state_nx = S_IDLE;
                S_ARMED: if (final_hit)
                             state_nx = (post_quota == (AW+1)'(1)) ? S_DONE : S_POST;
                S_POST:  if (rem == (AW+1)'(1)) state_nx = S_DONE;
                S_DONE:  state_nx = S_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp       <= '0;
            cnt      <= '0;
            rem      <= '0;
            stage    <= '0;
            trig_ptr <= '0;
            trig_pos <= '0;
            rp       <= '0;
            pos_q    <= POS_PRE;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (we) wp <= wp_inc;
            if (arm_go) begin
                cnt   <= '0;
                stage <= '0;
                pos_q <= pos_sel;
            end else if (state == S_ARMED && !stop) begin
                if (cnt < FULL) cnt <= cnt + (AW+1)'(1);
                if (final_hit) begin
                    trig_ptr <= wp;
                    rem      <= post_quota - (AW+1)'(1);
                    if (post_quota == (AW+1)'(1)) begin
                        rp       <= wp_inc;
                        trig_pos <= wp - wp_inc;
                    end
                end else if (stage != last_stage && hit[stage]) begin
                    stage <= stage + GW'(1);
                end
            end else if (state == S_POST && !stop) begin
                rem <= rem - (AW+1)'(1);
                if (rem == (AW+1)'(1)) begin
                    rp       <= wp_inc;
                    trig_pos <= trig_ptr - wp_inc;
                end
            end else if (rd_go) begin
                rp <= rp + AW'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        armed     = 1'b0;
        triggered = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_ARMED: armed = 1'b1;
            S_POST:  begin armed = 1'b1; triggered = 1'b1; end
            S_DONE:  begin triggered = 1'b1; done = 1'b1; end
        endcase
    end

    assign we    = (state == S_ARMED) || (state == S_POST);
    assign waddr = wp;
    assign re    = rd_go;
    assign raddr = rp;
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 16,
    parameter int STAGES  = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int SW     = $clog2(STAGES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PROBE_W-1:0]        probe,
    input  logic [STAGES*PROBE_W-1:0] trig_val,
    input  logic [STAGES*PROBE_W-1:0] trig_mask,
    input  logic [SW-1:0]             used_stages,
    input  logic [1:0]                pos_sel,
    input  logic                      arm,
    input  logic                      stop,
    input  logic                      rd_en,
    output logic                      armed,
    output logic                      triggered,
    output logic                      done,
    output logic [AW-1:0]             trig_pos,
    output logic [PROBE_W-1:0]        rd_data,
    output logic                      rd_valid
);
    logic [STAGES-1:0] hit;
    logic              we, re;
    logic [AW-1:0]     waddr, raddr;

    cap_match #(.PROBE_W(PROBE_W), .STAGES(STAGES)) u_match (
        .probe(probe), .trig_val(trig_val), .trig_mask(trig_mask), .hit(hit)
    );

    cap_fsm #(.DEPTH(DEPTH), .STAGES(STAGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .used_stages(used_stages),
        .pos_sel(pos_sel), .arm(arm), .stop(stop), .rd_en(rd_en),
        .we(we), .waddr(waddr), .re(re), .raddr(raddr),
        .armed(armed), .triggered(triggered), .done(done),
        .trig_pos(trig_pos), .rd_valid(rd_valid)
    );

    cap_ram #(.PROBE_W(PROBE_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(probe),
        .re(re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          stop,
    input logic          armed,
    input logic          triggered,
    input logic          done,
    input logic          rd_valid,
    input logic [AW-1:0] trig_pos
);
    AST_ARM_START: assert property (@(posedge clk) disable iff (!rst_n)
        arm && !stop |=> armed && !triggered && !done);                   // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !armed && !triggered && !done);                          // R11
    AST_DONE_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed && triggered);                                    // R8
    AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        triggered && !arm && !stop |=> triggered);                        // R8
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm && !stop |=> done);                                  // R13
    AST_READ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(done));                                        // R12
    AST_TRIG_POS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trig_pos == AW'(1) || trig_pos == AW'(DEPTH/2)
                  || trig_pos == AW'(DEPTH-1)));                          // R10
endmodule

bind trig_capture cap_checker #(.DEPTH(DEPTH)) u_cap_checker (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .armed(armed),
    .triggered(triggered), .done(done), .rd_valid(rd_valid), .trig_pos(trig_pos)
);

// File: tb/test_trig_capture.sv
module test_trig_capture;
    localparam int W = 8, D = 16, NS = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0]  probe = '0;
    logic [NS*W-1:0] trig_val = '0, trig_mask = '0;
    logic [1:0]    used_stages = 2'd1, pos_sel = 2'd0;
    logic          arm = 1'b0, stop = 1'b0, rd_en = 1'b0;
    logic          armed, triggered, done, rd_valid;
    logic [3:0]    trig_pos;
    logic [W-1:0]  rd_data;

    int checks = 0, errors = 0;
    logic [W-1:0] exp_q[$];
    string        cur_req = "R9";

    always #4 clk = ~clk;
    always @(negedge clk) probe <= probe + 8'd1;

    trig_capture #(.PROBE_W(W), .DEPTH(D), .STAGES(NS)) i_trig_capture (
        .clk(clk), .rst_n(rst_n), .probe(probe), .trig_val(trig_val),
        .trig_mask(trig_mask), .used_stages(used_stages), .pos_sel(pos_sel),
        .arm(arm), .stop(stop), .rd_en(rd_en), .armed(armed),
        .triggered(triggered), .done(done), .trig_pos(trig_pos),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_probe(input logic [W-1:0] v);
        do @(negedge clk); while (probe != v);
    endtask

    task automatic arm_at(input logic [W-1:0] v);
        wait_probe(v);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 1000) begin @(negedge clk); n++; end
        chk(req, done, 1);
    endtask

    // driver: queue expected window then issue reads
    task automatic read_window(input logic [W-1:0] base, input string req);
        cur_req = req;
        for (int k = 0; k < D; k++) exp_q.push_back(base + W'(k));
        for (int k = 0; k < D; k++) begin rd_en = 1'b1; @(negedge clk); end
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        chk({req, " queue drained"}, exp_q.size(), 0);
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected read actual %0h expected none", cur_req, rd_data);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: read actual %0h expected %0h", cur_req, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 armed", armed, 0);
        chk("R1 triggered", triggered, 0);
        chk("R1 done", done, 0);
        chk("R1 rd_valid", rd_valid, 0);

        // R12 read while idle ignored
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R12 rd_valid idle", rd_valid, 0);

        // early position, single stage on 0x50: PRE=1
        used_stages = 2'd1; pos_sel = 2'd0;
        trig_val = {8'hEE, 8'h50}; trig_mask = '0;
        arm_at(8'h30);
        chk("R2 armed", armed, 1);
        chk("R2 triggered", triggered, 0);
        wait_done("R8 done early");
        chk("R8 armed low at done", armed, 0);
        chk("R10 trig_pos early", trig_pos, 1);
        read_window(8'h4F, "R9 R6 early window");
        chk("R13 done held", done, 1);

        // center, two stages: 0x80 then 0x70 (R5 ordering)
        used_stages = 2'd2; pos_sel = 2'd1;
        trig_val = {8'h70, 8'h80};
        arm_at(8'h60);
        chk("R2 rearm from done", {armed, triggered, done}, 3'b100);
        wait_probe(8'h78);
        chk("R5 later stage first ignored", triggered, 0);
        wait_probe(8'h90);
        chk("R5 waiting on stage 1", triggered, 0);
        wait_done("R5 sequence done");
        chk("R10 trig_pos center", trig_pos, 8);
        read_window(8'h68, "R5 R6 center window");

        // late position, masked match 0x3X (R4), eligibility gates 0x2X
        used_stages = 2'd1; pos_sel = 2'd2;
        trig_val = {8'h00, 8'h3F}; trig_mask = {8'h00, 8'h0F};
        arm_at(8'h10);
        wait_done("R4 masked done");
        chk("R10 trig_pos late", trig_pos, 15);
        read_window(8'h21, "R4 R3 late window");
        read_window(8'h21, "R9 wrap reread");

        // R7: trigger value seen before PRE samples is ignored
        trig_val = {8'h00, 8'hA0}; trig_mask = '0;
        arm_at(8'h9B);
        wait_probe(8'hA8);
        chk("R7 early match ignored", triggered, 0);
        wait_done("R7 done");
        read_window(8'h91, "R7 window");

        // R11: stop aborts, no done
        pos_sel = 2'd0;
        arm_at(8'h00);
        @(negedge clk);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk("R11 stop status", {armed, triggered, done}, 3'b000);
        repeat (300) @(negedge clk);
        chk("R11 no capture after stop", done, 0);
        arm = 1'b1; stop = 1'b1; @(negedge clk);
        arm = 1'b0; stop = 1'b0;
        chk("R11 stop beats arm", armed, 0);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R12 rd_valid after stop", rd_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule